// File: doc/BRIEF.md
# SMBus Slave Register-Pointer Interface

This block is the serial front end of a small peripheral register file. It watches the two open-drain bus lines and detects start and stop conditions from them. It answers one fixed 7-bit device address and pulls the data line low when it has to acknowledge a byte or send a zero bit. It does not store any register contents. It keeps only the pointer that selects a register and offers a plain read/write port to the register file next to it.

A write transaction always carries a pointer byte. It may carry one data byte after that, which is written to the register the pointer selects. A read transaction carries no pointer. It returns exactly one byte, from the register chosen by an earlier write. A host therefore reads a register in one of two ways: a pointer-only write followed by a read, or a pointer write followed by a repeated start and a read. The bus inputs pass through a synchronizer, and all edges are detected on the system clock. The system clock must run at least eight times faster than the serial clock.

Top module: `smb_ptr_slave`

## Requirements
- R1: The first byte after a start is received MSB first. The block compares its bits 7:1 with the device address 0x4C; bit 0 selects the direction (0 write, 1 read). On a match the block pulls SDA low during the ninth (acknowledge) clock.
- R2: When the address does not match, the block never pulls SDA low and performs no register write until the next start. Bytes clocked in that state read as 0xFF on the bus and leave `reg_addr` unchanged.
- R3: In a write, the first byte after the address byte is loaded into the pointer, which appears on `reg_addr`. The block acknowledges that byte.
- R4: In a write, the second byte after the address byte is written to the register the pointer selects. `reg_we` is high for exactly one system clock, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The block acknowledges the byte.
- R5: A write that stops after the pointer byte updates the pointer and causes no `reg_we` pulse.
- R6: In a read, the block drives `reg_rdata` for the current pointer onto SDA, MSB first, during the eight clocks after the address acknowledge. It releases SDA for the master's acknowledge bit.
- R7: In a write, every byte after the data byte is not acknowledged (SDA released on the ninth clock) and is not written.
- R8: The pointer does not change after a read, after a data write, or after discarded bytes.
- R9: A start arriving at any bit position (repeated start) abandons the current frame and begins address reception anew. This also covers a pointer write followed directly by a read.
- R10: A stop releases SDA and returns the block to idle. Clocks sent after a stop without a new start are neither acknowledged nor written.
- R11: After reset, SDA is released, `reg_we` is low and the pointer is 0.
- R12: `sda_pull` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line as received from the bus |
| sda_in | input | 1 | Serial data line as received from the bus |
| sda_pull | output | 1 | 1 = pull the data line low; 0 = release it |
| reg_addr | output | PTR_W | Current pointer; register select for reads and writes |
| reg_wdata | output | 8 | Byte to store when `reg_we` is high |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Register file contents at `reg_addr` |

## Verification
The hardest cases to reach are the ones where the bus sequence breaks off part-way. One is a start that arrives in the middle of a byte. Another is a pointer write that turns into a read without a stop in between. To create them, the bench's bus master tasks clock a chosen number of single bits, then issue a repeated start with SCL low. The bench then checks that the following complete transaction writes to the right register or returns the right byte. Address mismatches and extra write bytes are driven the same way, and a scoreboard confirms that no write strobe reaches the register file.

// File: rtl/smb_pkg.sv
`timescale 1ns/1ps
package smb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SEND,
    ST_MACK,
    ST_SKIP
  } smb_state_e;

  typedef enum logic [1:0] {
    IDX_ADDR  = 2'd0,
    IDX_PTR   = 2'd1,
    IDX_DATA  = 2'd2,
    IDX_EXTRA = 2'd3
  } smb_idx_e;
endpackage

// File: rtl/smb_sync.sv
`timescale 1ns/1ps
module smb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= '1;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= '1;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/smb_cond_det.sv
`timescale 1ns/1ps
module smb_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      scl_rise  <= 1'b0;
      scl_fall  <= 1'b0;
      start_det <= 1'b0;
      stop_det  <= 1'b0;
    end else begin
      scl_q     <= scl_s;
      sda_q     <= sda_s;
      scl_rise  <= scl_s & ~scl_q;
      scl_fall  <= ~scl_s & scl_q;
      // SDA moving while SCL is held high marks a bus condition
      start_det <= scl_s & scl_q & sda_q & ~sda_s;
      stop_det  <= scl_s & scl_q & ~sda_q & sda_s;
    end
  end
endmodule

// File: rtl/smb_frame_ctrl.sv
`timescale 1ns/1ps
module smb_frame_ctrl
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h4C,
  parameter int         PTR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rdata,
  output logic              sda_pull,
  output logic [PTR_W-1:0]  ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  smb_state_e        state;
  smb_idx_e          idx;
  logic [CNT_W-1:0]  cnt;
  logic              rw;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-2:0] txreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      idx      <= IDX_ADDR;
      cnt      <= '0;
      rw       <= 1'b0;
      shreg    <= '0;
      txreg    <= '0;
      ptr      <= '0;
      wr_en    <= 1'b0;
      wr_data  <= '0;
      sda_pull <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= ST_RECV;
        idx      <= IDX_ADDR;
        cnt      <= '0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        state    <= ST_IDLE;
        sda_pull <= 1'b0;
      end else begin
        case (state)
          ST_RECV: begin
            if (scl_rise) begin
              shreg <= {shreg[BYTE_W-2:0], sda_s};
              cnt   <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == CNT_FULL) begin
              cnt <= '0;
              case (idx)
                IDX_ADDR: begin
                  if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                    rw       <= shreg[0];
                    sda_pull <= 1'b1;
                    state    <= ST_ACK;
                  end else begin
                    state <= ST_SKIP;
                  end
                end
                IDX_PTR: begin
                  ptr      <= shreg[PTR_W-1:0];
                  sda_pull <= 1'b1;
                  state    <= ST_ACK;
                end
                IDX_DATA: begin
                  wr_en    <= 1'b1;
                  wr_data  <= shreg;
                  sda_pull <= 1'b1;
                  state    <= ST_ACK;
                end
                default: state <= ST_ACK;  // surplus byte: line left released
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (idx == IDX_ADDR && rw) begin
                txreg    <= rdata[BYTE_W-2:0];
                sda_pull <= ~rdata[BYTE_W-1];
                cnt      <= '0;
                state    <= ST_SEND;
              end else begin
                sda_pull <= 1'b0;
                state    <= ST_RECV;
                if (idx != IDX_EXTRA) idx <= smb_idx_e'(idx + 2'd1);
              end
            end
          end
          ST_SEND: begin
            if (scl_fall) begin
              if (cnt == CNT_LAST) begin
                sda_pull <= 1'b0;
                state    <= ST_MACK;
              end else begin
                sda_pull <= ~txreg[BYTE_W-2];
                txreg    <= {txreg[BYTE_W-3:0], 1'b0};
                cnt      <= cnt + CNT_W'(1);
              end
            end
          end
          ST_MACK: if (scl_fall) state <= ST_SKIP;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_ptr_slave.sv
`timescale 1ns/1ps
module smb_ptr_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h4C,
  parameter int         PTR_W       = 8,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_pull,
  output logic [PTR_W-1:0] reg_addr,
  output logic [7:0]       reg_wdata,
  output logic             reg_we,
  input  logic [7:0]       reg_rdata
);
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  smb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in ({scl_in, sda_in}),
    .sync_out ({scl_s, sda_s})
  );

  smb_cond_det u_cond (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  smb_frame_ctrl #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .rdata     (reg_rdata),
    .sda_pull  (sda_pull),
    .ptr       (reg_addr),
    .wr_en     (reg_we),
    .wr_data   (reg_wdata)
  );
endmodule

// File: rtl/smb_ptr_slave_chk.sv
`timescale 1ns/1ps
module smb_ptr_slave_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             sda_pull,
  input logic             reg_we,
  input logic [PTR_W-1:0] reg_addr,
  input logic             scl_s,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det
);
  // R11
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sda_pull && !reg_we));

  // R4
  we_single_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);

  // R4
  we_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> $past(scl_fall));

  // R8
  ptr_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(reg_addr) |-> $past(scl_fall));

  // R9
  start_release_chk: assert property (@(posedge clk) disable iff (rst)
    start_det |=> !sda_pull);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_pull);

  // R12
  pull_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(sda_pull) || $fell(sda_pull)) |-> !scl_s);
endmodule

bind smb_ptr_slave smb_ptr_slave_chk #(.PTR_W(PTR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sda_pull  (sda_pull),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .scl_s     (scl_s),
  .scl_fall  (scl_fall),
  .start_det (start_det),
  .stop_det  (stop_det)
);

// File: tb/test_smb_ptr_slave.sv
`timescale 1ns/1ps
module test_smb_ptr_slave;
  localparam int QTR = 20;
  localparam logic [6:0] ADDR = 7'h4C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  wire  sda_bus = m_sda & ~sda_pull;

  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

  smb_ptr_slave i_smb_ptr_slave (
    .clk(clk), .rst(rst), .scl_in(m_scl), .sda_in(sda_bus),
    .sda_pull(sda_pull), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  int checks = 0, errors = 0, r12_viol = 0;
  bit done = 0;

  typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_item_t;
  wr_item_t exp_q[$];

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every write strobe must match the next expected item
  always @(negedge clk) begin
    if (!rst && reg_we) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5/R7 unexpected write", {reg_addr, reg_wdata}, 32'h0);
      end else begin
        wr_item_t it;
        it = exp_q.pop_front();
        check(reg_addr == it.a && reg_wdata == it.d, "R4 write", {reg_addr, reg_wdata}, {it.a, it.d});
      end
    end
  end

  // R12 observer: pull must hold while SCL stays high
  logic prev_scl = 1'b1, prev_pull = 1'b0;
  always @(negedge clk) begin
    if (!rst && m_scl && prev_scl && sda_pull != prev_pull) r12_viol++;
    prev_scl  <= m_scl;
    prev_pull <= sda_pull;
  end

  task automatic q;
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; q; m_scl = 1'b1; q; m_sda = 1'b0; q; m_scl = 1'b0; q;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; q; m_scl = 1'b1; q; m_sda = 1'b1; q; q;
  endtask

  task automatic clk_bit(input logic b, output logic seen);
    m_sda = b; q; m_scl = 1'b1; q; seen = sda_bus; q; m_scl = 1'b0; q;
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
    clk_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      v[i] = s;
    end
    clk_bit(1'b1, s);  // master NACK
  endtask

  task automatic wr_reg(input logic [7:0] p, input logic [7:0] d);
    logic ack;
    bus_start;
    send_byte({ADDR, 1'b0}, ack); check(ack, "R1 addr ack", ack, 1);
    send_byte(p, ack);            check(ack, "R3 ptr ack", ack, 1);
    exp_q.push_back({p, d});
    exp_mem[p] = d;
    send_byte(d, ack);            check(ack, "R4 data ack", ack, 1);
    bus_stop;
    check(reg_addr == p, "R3 pointer", reg_addr, p);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    logic ack;
    bus_start;
    send_byte({ADDR, 1'b0}, ack); check(ack, "R1 addr ack", ack, 1);
    send_byte(p, ack);            check(ack, "R5 ptr ack", ack, 1);
    bus_stop;
    check(reg_addr == p, "R5 pointer only", reg_addr, p);
  endtask

  task automatic rd_reg(input logic [7:0] p);
    logic ack;
    logic [7:0] v;
    bus_start;
    send_byte({ADDR, 1'b1}, ack); check(ack, "R1 read addr ack", ack, 1);
    recv_byte(v);
    check(v == exp_mem[p], "R6 read data", v, exp_mem[p]);
    check(!sda_pull, "R6 released after byte", sda_pull, 0);
    bus_stop;
    check(reg_addr == p, "R8 no increment after read", reg_addr, p);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i) ^ 8'h5A;
      exp_mem[i] = 8'(i) ^ 8'h5A;
    end
  end

  initial begin
    logic ack, s;
    logic [7:0] v;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(!sda_pull && !reg_we && reg_addr == 8'h00, "R11 reset state",
          {sda_pull, reg_we, reg_addr}, 0);

    // plain writes and reads
    wr_reg(8'h10, 8'hA5);
    wr_reg(8'h11, 8'h3C);
    set_ptr(8'h10);
    rd_reg(8'h10);
    rd_reg(8'h10);
    set_ptr(8'h80);
    rd_reg(8'h80);

    // R7: surplus write bytes
    bus_start;
    send_byte({ADDR, 1'b0}, ack); check(ack, "R1 addr ack", ack, 1);
    send_byte(8'h22, ack);        check(ack, "R3 ptr ack", ack, 1);
    exp_q.push_back({8'h22, 8'h99}); exp_mem[8'h22] = 8'h99;
    send_byte(8'h99, ack);        check(ack, "R4 data ack", ack, 1);
    send_byte(8'h55, ack);        check(!ack, "R7 surplus nack", ack, 0);
    send_byte(8'h66, ack);        check(!ack, "R7 surplus nack 2", ack, 0);
    bus_stop;
    check(reg_addr == 8'h22, "R8 no increment after write", reg_addr, 8'h22);

    // R2: foreign address, write then read
    bus_start;
    send_byte({7'h4D, 1'b0}, ack); check(!ack, "R2 mismatch nack", ack, 0);
    send_byte(8'h33, ack);         check(!ack, "R2 ignored byte", ack, 0);
    send_byte(8'h44, ack);         check(!ack, "R2 ignored byte 2", ack, 0);
    bus_stop;
    check(reg_addr == 8'h22, "R2 pointer kept", reg_addr, 8'h22);
    bus_start;
    send_byte({7'h0C, 1'b1}, ack); check(!ack, "R2 mismatch read nack", ack, 0);
    recv_byte(v);                  check(v == 8'hFF, "R2 line not driven", v, 8'hFF);
    bus_stop;

    // R9: repeated start in the middle of a pointer byte
    bus_start;
    send_byte({ADDR, 1'b0}, ack);
    clk_bit(1'b0, s); clk_bit(1'b1, s); clk_bit(1'b1, s);
    bus_start;
    send_byte({ADDR, 1'b0}, ack); check(ack, "R9 addr after restart", ack, 1);
    send_byte(8'h30, ack);        check(ack, "R9 ptr after restart", ack, 1);
    exp_q.push_back({8'h30, 8'h5E}); exp_mem[8'h30] = 8'h5E;
    send_byte(8'h5E, ack);
    bus_stop;
    check(reg_addr == 8'h30, "R9 pointer after restart", reg_addr, 8'h30);

    // R9: pointer write then repeated start into a read
    bus_start;
    send_byte({ADDR, 1'b0}, ack);
    send_byte(8'h11, ack);
    bus_start;
    send_byte({ADDR, 1'b1}, ack); check(ack, "R9 combined read ack", ack, 1);
    recv_byte(v);                 check(v == 8'h3C, "R9 combined read data", v, 8'h3C);
    bus_stop;

    // R10: stop right after the address, then clocks without a start
    bus_start;
    send_byte({ADDR, 1'b0}, ack);
    bus_stop;
    check(!sda_pull, "R10 released after stop", sda_pull, 0);
    m_scl = 1'b0; q;
    send_byte({ADDR, 1'b0}, ack); check(!ack, "R10 no ack without start", ack, 0);
    send_byte(8'h77, ack);        check(!ack, "R10 ignored byte", ack, 0);
    m_sda = 1'b1; q; m_scl = 1'b1; q;
    check(reg_addr == 8'h11, "R10 pointer kept", reg_addr, 8'h11);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R4 missing write", exp_q.size(), 0);
    check(r12_viol == 0, "R12 pull changed with SCL high", r12_viol, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule